// File: doc/BRIEF.md
# Thread-Block Dispatcher with Dual Occupancy Limits

This block takes one launched grid, described by a block count and a thread count per block, and hands its blocks out one at a time to a fixed set of multiprocessor slots. Each slot has two capacity limits, and a block may go to a slot only while both hold:

- a cap on the number of resident blocks;
- a cap on the number of resident threads.

Which of the two limits binds depends on the block size. Small blocks run into the block cap first. Large blocks run into the thread cap first.

Blocks leave the dispatcher on a valid/ready stream. Each beat carries the block index and the chosen slot. Once `disp_valid` is raised, the index and slot stay frozen until the consumer raises `disp_ready`. The beat transfers on the edge where both are high.

When a block retires, its slot raises a completion pulse together with the retiring block's thread count. The freed capacity is available for admission on the following cycle. The launch input is also a valid/ready handshake. It is ready whenever no grid is in flight. A launch with an illegal block size raises a size error and dispatches nothing. `grid_done` marks the point where every block of the grid has been dispatched and has retired.

Top module: `tbd_dispatch_top`

## Requirements
- R1: A launch with 0 or more than MAX_TPB (1024) threads per block sets `size_err` from the next cycle until the next accepted launch. While `size_err` is set, no block is offered and `grid_done` stays 0. A size of exactly 1024 is legal.
- R2: No slot ever holds more than MAX_BLK (8) resident blocks. A slot at this count is never chosen.
- R3: No slot ever holds more than MAX_THR (1536) resident threads. A block is offered to a slot only if the slot's resident threads plus the block size stay within this cap. The whole block goes to that one slot.
- R4: The slot is chosen round-robin. The search starts at the slot after the last one that received a block, and after reset it starts at slot 0. Slots without room are skipped.
- R5: Block indices are offered in ascending order from 0 to count−1. At most one block transfers per cycle. `disp_valid` is high exactly when blocks remain and some slot has room, or when an offer is already being held.
- R6: While `disp_valid` is high and `disp_ready` is low, `disp_idx` and `disp_slot` hold their values on the next cycle. This holds even if a completion frees an earlier slot in the round-robin order.
- R7: A completion pulse on slot s returns one block and `cpl_threads[s*11 +: 11]` threads to that slot. The freed room can be used by an offer in the very next cycle.
- R8: `grid_done` rises once all blocks have been dispatched and every slot is empty. A zero-block launch sets it one cycle after acceptance. It clears in the cycle after the next accepted launch. `launch_ready` is low only while a grid is running.
- R9: The caps produce these per-slot occupancies:
  - 64-thread blocks: 8 per slot (512 threads);
  - 256-thread blocks: 6 per slot;
  - 1024-thread blocks: 1 per slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_valid | input | 1 | Launch request |
| launch_ready | output | 1 | High when no grid is running |
| launch_blocks | input | GW (16) | Number of blocks in the grid |
| launch_tpb | input | PW (11) | Threads per block |
| disp_valid | output | 1 | A block is being offered |
| disp_ready | input | 1 | Consumer accepts the offered block |
| disp_idx | output | GW (16) | Index of the offered block |
| disp_slot | output | SW (2) | Slot chosen for the offered block |
| cpl_pulse | input | NSLOT (4) | One completion pulse per slot |
| cpl_threads | input | NSLOT*PW (44) | Thread count of the retiring block, one field per slot |
| size_err | output | 1 | Last launch had an illegal block size |
| grid_done | output | 1 | All blocks dispatched and retired |

## Verification
The bench drives grids of 64-, 256- and 1024-thread blocks until every slot saturates. A design that compared against only one cap would overfill slots. For 64-thread blocks it would admit more than 8 per slot, and for 256-thread blocks it would admit more than 6.

A completion is placed while all slots are full. This shows that freed room is reused one cycle later, and not lost or delayed. Another completion frees an earlier slot while an offer is stalled by back-pressure. A picker that re-evaluated during the stall would change `disp_slot` mid-handshake.

Further runs check the size boundaries 0, 1024 and 1025 and a zero-block grid. A reference model of the round-robin order checks every offered slot and index.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_BAD  = 2'd3
  } tbd_state_e;
endpackage

// File: rtl/tbd_slot_ctr.sv
module tbd_slot_ctr #(
  parameter int MAXB = 8,
  parameter int MAXT = 1536,
  parameter int PW   = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [PW-1:0] tpb,
  input  logic          cpl,
  input  logic [PW-1:0] cpl_thr,
  output logic          fits,
  output logic          empty
);
  localparam int BW = $clog2(MAXB + 1);
  localparam int TW = $clog2(MAXT + 1);

  logic [BW-1:0] blk_q;
  logic [TW-1:0] thr_q;
  logic [TW:0]   need;

  // Room check uses registered counts only, so a completion shows up next cycle.
  assign need  = {1'b0, thr_q} + (TW+1)'(tpb);
  assign fits  = (blk_q < BW'(MAXB)) && (need <= (TW+1)'(MAXT));
  assign empty = (blk_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      thr_q <= '0;
    end else begin
      blk_q <= blk_q + BW'(take) - BW'(cpl);
      thr_q <= thr_q + (take ? TW'(tpb) : '0) - (cpl ? TW'(cpl_thr) : '0);
    end
  end

  AST_BLK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q <= BW'(MAXB)); // R2
  AST_THR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q <= TW'(MAXT)); // R3
  AST_TAKE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> fits); // R3
  AST_TAKE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cpl) |=> blk_q == $past(blk_q) + BW'(1)); // R2
  AST_CPL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl && !take) |=> blk_q == $past(blk_q) - BW'(1)); // R7
endmodule

// File: rtl/tbd_rr_pick.sv
module tbd_rr_pick #(
  parameter int NSLOT = 4,
  parameter int SW    = 2
) (
  input  logic [NSLOT-1:0] fits,
  input  logic [SW-1:0]    last,
  output logic [SW-1:0]    pick,
  output logic             any
);
  always_comb begin
    pick = last;
    any  = 1'b0;
    for (int k = 1; k <= NSLOT; k++) begin
      int c;
      c = (int'(last) + k) % NSLOT;
      if (!any && fits[c]) begin
        any  = 1'b1;
        pick = SW'(c);
      end
    end
  end
endmodule

// File: rtl/tbd_launch_ctl.sv
module tbd_launch_ctl
  import tbd_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int SW    = 2,
  parameter int GW    = 16,
  parameter int PW    = 11,
  parameter int MAXP  = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_valid,
  output logic          launch_ready,
  input  logic [GW-1:0] launch_blocks,
  input  logic [PW-1:0] launch_tpb,
  input  logic          any_fit,
  input  logic [SW-1:0] pick,
  input  logic          all_empty,
  input  logic          disp_ready,
  output logic          disp_valid,
  output logic [GW-1:0] disp_idx,
  output logic [SW-1:0] disp_slot,
  output logic          fire,
  output logic [PW-1:0] tpb_q,
  output logic [SW-1:0] last_q,
  output logic          size_err,
  output logic          grid_done
);
  tbd_state_e    st_q;
  logic [GW-1:0] n_q, idx_q;
  logic          stall_q;
  logic [SW-1:0] stall_slot_q;
  logic          accept, legal, remain;

  assign launch_ready = (st_q != ST_RUN);
  assign accept       = launch_valid && launch_ready;
  assign legal        = (launch_tpb != '0) && (launch_tpb <= PW'(MAXP));
  assign remain       = (idx_q < n_q);
  assign disp_valid   = (st_q == ST_RUN) && remain && (stall_q || any_fit);
  assign disp_slot    = stall_q ? stall_slot_q : pick;
  assign disp_idx     = idx_q;
  assign fire         = disp_valid && disp_ready;
  assign size_err     = (st_q == ST_BAD);
  assign grid_done    = (st_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      n_q          <= '0;
      idx_q        <= '0;
      tpb_q        <= '0;
      last_q       <= SW'(NSLOT - 1);
      stall_q      <= 1'b0;
      stall_slot_q <= '0;
    end else begin
      stall_q      <= disp_valid && !disp_ready;
      stall_slot_q <= disp_slot;
      if (fire) begin
        idx_q  <= idx_q + GW'(1);
        last_q <= disp_slot;
      end
      if (accept) begin
        idx_q   <= '0;
        n_q     <= launch_blocks;
        tpb_q   <= launch_tpb;
        stall_q <= 1'b0;
        st_q    <= legal ? ST_RUN : ST_BAD;
      end else if (st_q == ST_RUN && !remain && all_empty) begin
        st_q <= ST_FIN;
      end
    end
  end

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> disp_valid && $stable(disp_slot) && $stable(disp_idx)); // R6
  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !disp_valid && !grid_done); // R1
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    grid_done |-> all_empty && !disp_valid); // R8
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !accept) |=> disp_idx == $past(disp_idx) + GW'(1)); // R5
endmodule

// File: rtl/tbd_dispatch_top.sv
module tbd_dispatch_top #(
  parameter int NSLOT = 4,
  parameter int MAXB  = 8,
  parameter int MAXT  = 1536,
  parameter int MAXP  = 1024,
  parameter int GW    = 16,
  parameter int PW    = $clog2(MAXP + 1),
  parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch_valid,
  output logic                launch_ready,
  input  logic [GW-1:0]       launch_blocks,
  input  logic [PW-1:0]       launch_tpb,
  output logic                disp_valid,
  input  logic                disp_ready,
  output logic [GW-1:0]       disp_idx,
  output logic [SW-1:0]       disp_slot,
  input  logic [NSLOT-1:0]    cpl_pulse,
  input  logic [NSLOT*PW-1:0] cpl_threads,
  output logic                size_err,
  output logic                grid_done
);
  logic [NSLOT-1:0] fits, empty, take;
  logic [SW-1:0]    pick, last;
  logic             any_fit, fire;
  logic [PW-1:0]    tpb;

  tbd_launch_ctl #(
    .NSLOT(NSLOT), .SW(SW), .GW(GW), .PW(PW), .MAXP(MAXP)
  ) ctl_i (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_blocks(launch_blocks), .launch_tpb(launch_tpb),
    .any_fit(any_fit), .pick(pick), .all_empty(&empty),
    .disp_ready(disp_ready), .disp_valid(disp_valid),
    .disp_idx(disp_idx), .disp_slot(disp_slot),
    .fire(fire), .tpb_q(tpb), .last_q(last),
    .size_err(size_err), .grid_done(grid_done)
  );

  tbd_rr_pick #(.NSLOT(NSLOT), .SW(SW)) pick_i (
    .fits(fits), .last(last), .pick(pick), .any(any_fit)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign take[s] = fire && (disp_slot == SW'(s));
    tbd_slot_ctr #(.MAXB(MAXB), .MAXT(MAXT), .PW(PW)) ctr_i (
      .clk(clk), .rst_n(rst_n),
      .take(take[s]), .tpb(tpb),
      .cpl(cpl_pulse[s]), .cpl_thr(cpl_threads[s*PW +: PW]),
      .fits(fits[s]), .empty(empty[s])
    );
  end

  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take)); // R5
endmodule

// File: tb/tbd_dispatch_top_tb_top.sv
module tbd_dispatch_top_tb_top;
  localparam int N  = 4;
  localparam int PW = 11;
  localparam int GW = 16;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launch_valid = 1'b0;
  logic launch_ready;
  logic [GW-1:0] launch_blocks = '0;
  logic [PW-1:0] launch_tpb = '0;
  logic disp_valid;
  logic disp_ready = 1'b0;
  logic [GW-1:0] disp_idx;
  logic [SW-1:0] disp_slot;
  logic [N-1:0] cpl_pulse = '0;
  logic [N*PW-1:0] cpl_threads = '0;
  logic size_err, grid_done;

  always #10 clk = ~clk;

  tbd_dispatch_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_blocks(launch_blocks), .launch_tpb(launch_tpb),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_idx(disp_idx), .disp_slot(disp_slot),
    .cpl_pulse(cpl_pulse), .cpl_threads(cpl_threads),
    .size_err(size_err), .grid_done(grid_done)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit ended = 0;

  int m_blk[N];
  int m_thr[N];
  int disp_cnt[N];
  int m_last = N - 1;
  int m_idx = 0, m_n = 0, m_tpb = 0;
  bit m_run = 0, m_stall = 0;
  int m_stall_slot = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pick();
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (m_last + k) % N;
      if (m_blk[c] < 8 && m_thr[c] + m_tpb <= 1536) return c;
    end
    return -1;
  endfunction

  task automatic step(input bit rdy, input logic [N-1:0] mask);
    int es;
    bit ev;
    disp_ready = rdy;
    cpl_pulse  = mask;
    for (int s = 0; s < N; s++) cpl_threads[s*PW +: PW] = PW'(m_tpb);
    #1;
    es = m_stall ? m_stall_slot : exp_pick();
    ev = m_run && (m_idx < m_n) && (es >= 0);
    chk(disp_valid === ev, "R5 valid", int'(disp_valid), int'(ev));
    if (ev && disp_valid) begin
      chk(int'(disp_idx) == m_idx, "R5 index", int'(disp_idx), m_idx);
      chk(int'(disp_slot) == es, "R4 slot", int'(disp_slot), es);
    end
    @(posedge clk);
    if (ev && rdy) begin
      m_blk[es]++;
      m_thr[es] += m_tpb;
      disp_cnt[es]++;
      m_last = es;
      m_idx++;
      m_stall = 0;
    end else if (ev) begin
      m_stall = 1;
      m_stall_slot = es;
    end else begin
      m_stall = 0;
    end
    for (int s = 0; s < N; s++) begin
      if (mask[s]) begin
        m_blk[s]--;
        m_thr[s] -= m_tpb;
      end
    end
    @(negedge clk);
    cpl_pulse = '0;
  endtask

  task automatic launch(input int n, input int tpb);
    bit legal;
    legal = (tpb >= 1) && (tpb <= 1024);
    chk(launch_ready === 1'b1, "R8 launch_ready", int'(launch_ready), 1);
    launch_valid  = 1'b1;
    launch_blocks = GW'(n);
    launch_tpb    = PW'(tpb);
    disp_ready    = 1'b0;
    @(posedge clk);
    m_stall = 0;
    m_run   = legal;
    m_idx   = 0;
    m_n     = n;
    if (legal) m_tpb = tpb;
    for (int s = 0; s < N; s++) disp_cnt[s] = 0;
    @(negedge clk);
    launch_valid = 1'b0;
    chk(grid_done === 1'b0, "R8 done clears", int'(grid_done), 0);
    chk(size_err === !legal, "R1 size_err", int'(size_err), int'(!legal));
  endtask

  task automatic fill(input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b1, '0);
  endtask

  task automatic drain();
    int rs;
    rs = 0;
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] mask;
      if (grid_done === 1'b1) break;
      mask = '0;
      for (int k = 0; k < N; k++) begin
        int c;
        c = (rs + k) % N;
        if (mask == '0 && m_blk[c] > 0) mask[c] = 1'b1;
      end
      rs++;
      step(1'b1, mask);
    end
    chk(grid_done === 1'b1, "R8 grid_done", int'(grid_done), 1);
    chk(launch_ready === 1'b1, "R8 ready after done", int'(launch_ready), 1);
  endtask

  task automatic t_reset();
    chk(launch_ready === 1'b1, "R8 reset ready", int'(launch_ready), 1);
    chk(disp_valid === 1'b0, "R5 reset valid", int'(disp_valid), 0);
    chk(grid_done === 1'b0, "R8 reset done", int'(grid_done), 0);
    chk(size_err === 1'b0, "R1 reset err", int'(size_err), 0);
  endtask

  task automatic t_illegal();
    launch(5, 1025);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, '0);
      chk(size_err === 1'b1 && grid_done === 1'b0, "R1 err held", int'(size_err), 1);
    end
    launch(5, 0);
    step(1'b1, '0);
    chk(disp_valid === 1'b0, "R1 no dispatch", int'(disp_valid), 0);
  endtask

  task automatic t_zero();
    launch(0, 32);
    chk(size_err === 1'b0, "R1 err clears", int'(size_err), 0);
    step(1'b1, '0);
    chk(grid_done === 1'b1, "R8 zero grid", int'(grid_done), 1);
  endtask

  task automatic t_small();
    launch(40, 64);
    fill(40);
    for (int s = 0; s < N; s++) chk(disp_cnt[s] == 8, "R9 64-thread occupancy", disp_cnt[s], 8);
    chk(disp_valid === 1'b0, "R2 block cap stalls", int'(disp_valid), 0);
    step(1'b1, 4'b0100);
    chk(disp_valid === 1'b1 && disp_slot == 2'd2, "R7 freed slot reused", int'(disp_slot), 2);
    drain();
  endtask

  task automatic t_mid();
    launch(30, 256);
    fill(30);
    for (int s = 0; s < N; s++) chk(disp_cnt[s] == 6, "R9 256-thread occupancy", disp_cnt[s], 6);
    chk(disp_valid === 1'b0, "R3 thread cap stalls", int'(disp_valid), 0);
    drain();
  endtask

  task automatic t_big_stall();
    int x, y;
    launch(6, 1024);
    fill(6);
    for (int s = 0; s < N; s++) chk(disp_cnt[s] == 1, "R9 1024-thread occupancy", disp_cnt[s], 1);
    y = (m_last + 1) % N;
    x = (m_last + 2) % N;
    step(1'b0, 4'(1 << x));
    step(1'b0, 4'(1 << y));
    chk(disp_valid === 1'b1 && int'(disp_slot) == x, "R6 held slot", int'(disp_slot), x);
    step(1'b0, '0);
    chk(int'(disp_slot) == x && int'(disp_idx) == 4, "R6 held index", int'(disp_idx), 4);
    step(1'b1, '0);
    chk(disp_valid === 1'b1 && int'(disp_slot) == y, "R4 next after held", int'(disp_slot), y);
    step(1'b1, '0);
    drain();
  endtask

  initial begin
    for (int s = 0; s < N; s++) begin
      m_blk[s] = 0;
      m_thr[s] = 0;
      disp_cnt[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_illegal();
    t_zero();
    t_small();
    t_mid();
    t_big_stall();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule